// File: doc/BRIEF.md
# Timestamp Event Queue

This block records timing events from several sources and holds them in a 16-entry first-in first-out queue until software reads and removes them. The sources are a software push command, eight hardware input lines, packet receive and transmit indications from an Ethernet MAC, and a compare-match strobe from the time counter. When an event is captured, the block stores the free-running time value `ts_now` from outside the block as a 64-bit timestamp. It also stores a descriptor that holds the event type, the port number, the protocol message type and sequence ID, and a domain byte.

Software sees the oldest entry through four read registers. It removes that entry by writing a pop command. A raw pending bit is high while the queue holds anything. The interrupt output follows that bit, gated by an enable bit. Each source first lands in its own one-deep holding slot. A fixed-priority arbiter then moves one slot per cycle into the queue. An event that cannot be stored sets a sticky overflow flag: either its source slot is still occupied, or the queue is full.

The queue occupancy is tracked by a three-state machine:
- EMPTY goes to PARTIAL on a write.
- PARTIAL goes to FULL when the write fills the last slot.
- PARTIAL goes back to EMPTY when a pop drains the last entry.
- FULL goes to PARTIAL on a pop.
- Every state holds when there is no write and no pop.

Top module: `tsq_event_queue`

## Requirements
- R1: After reset the queue is empty. The raw status, masked status, control register, overflow flag and `irq_o` all read 0.
- R2: Register addresses (word index on `reg_addr`) are: 0 control, 1 interrupt enable, 2 raw status, 3 masked status, 4 push, 5 pop, 6 timestamp bits 31:0, 7 descriptor, 8 domain, 9 timestamp bits 63:32. The descriptor holds sequence ID in bits 15:0, message type in 19:16, event type in 23:20 and port number in 28:24. The domain word holds the domain in bits 7:0. All other bits read 0.
- R3: Event type codes are 0 software push, 1 rollover, 2 half rollover, 3 hardware input, 4 receive, 5 transmit, 6 compare, 7 host transmit. A packet event takes type 5 when `pkt_is_tx` is 1 and type 4 otherwise. Software push and compare events carry port 0, message type 0, sequence 0 and domain 0.
- R4: Entries leave in arrival order. Writing 1 to bit 0 of the pop register removes the head entry. The stored timestamp is the `ts_now` value at the capture edge.
- R5: A pop while the queue is empty has no effect: the next event is still stored and read back correctly.
- R6: Raw status bit 0 is 1 exactly while the queue is non-empty. Masked status bit 0 and `irq_o` equal that bit ANDed with interrupt-enable bit 0.
- R7: Control bit 7+n enables hardware input n, for n from 1 to 8. A rising edge on an enabled input, after a two-flop synchronizer, makes an event of type 3 with port number n. An edge on a disabled input makes no event.
- R8: Sources that fire in the same cycle are enqueued one per cycle in this order: software push, hardware inputs 1 to 8 ascending, packet, compare.
- R9: The queue holds 16 entries, and further events are dropped. A dropped event sets raw status bit 1. That bit stays set, even after the queue drains, until software writes 1 to bit 1 of the raw status register.
- R10: A hardware input held high for many cycles makes exactly one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_now | input | 64 | Current time from the external counter |
| hw_in | input | 8 | Asynchronous hardware event inputs, channel n on bit n-1 |
| pkt_valid | input | 1 | One-cycle packet timestamp strobe |
| pkt_is_tx | input | 1 | 1 = transmit, 0 = receive |
| pkt_seq | input | 16 | Packet sequence ID |
| pkt_mtype | input | 4 | Packet message type |
| pkt_port | input | 5 | Packet port number |
| pkt_domain | input | 8 | Packet domain |
| cmp_hit | input | 1 | One-cycle compare-match strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| irq_o | output | 1 | Interrupt, pending AND enabled |

## Verification
The assertions take these things for granted:
- `pkt_valid` and `cmp_hit` are single-cycle strobes from logic on the same clock.
- The hardware inputs may be asynchronous.
- Register writes never target push and pop in the same cycle.

The bench drives every input on the falling edge and pulses each strobe for exactly one cycle. It raises hardware inputs only after the control register is settled, and it never overlaps a pop with a simultaneous write. Under those conditions, queue occupancy changes by at most one per cycle and the overflow flag has a single cause, a dropped event.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    localparam int TSQ_TS_W = 64;

    typedef enum logic [3:0] {
        EV_PUSH = 4'd0,
        EV_ROLL = 4'd1,
        EV_HALF = 4'd2,
        EV_HWIN = 4'd3,
        EV_RX   = 4'd4,
        EV_TX   = 4'd5,
        EV_CMP  = 4'd6,
        EV_HOST = 4'd7
    } tsq_evtype_e;

    typedef struct packed {
        logic [TSQ_TS_W-1:0] ts;
        logic [7:0]          domain;
        logic [4:0]          port;
        tsq_evtype_e         etype;
        logic [3:0]          mtype;
        logic [15:0]         seq;
    } tsq_entry_t;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } tsq_qstate_e;

    localparam logic [3:0] A_CTRL  = 4'd0;
    localparam logic [3:0] A_IRQEN = 4'd1;
    localparam logic [3:0] A_RAW   = 4'd2;
    localparam logic [3:0] A_MASK  = 4'd3;
    localparam logic [3:0] A_PUSH  = 4'd4;
    localparam logic [3:0] A_POP   = 4'd5;
    localparam logic [3:0] A_TSLO  = 4'd6;
    localparam logic [3:0] A_DESC  = 4'd7;
    localparam logic [3:0] A_DOM   = 4'd8;
    localparam logic [3:0] A_TSHI  = 4'd9;

endpackage

// File: rtl/tsq_sync_edge.sv
module tsq_sync_edge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    input  logic [N-1:0] en,
    output logic [N-1:0] rise
);
    for (genvar g = 0; g < N; g++) begin : g_ch
        logic s1, s2, s3;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= async_in[g];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign rise[g] = s2 & ~s3 & en[g];
    end
endmodule

// File: rtl/tsq_arbiter.sv
module tsq_arbiter
    import tsq_pkg::*;
#(
    parameter int NSRC = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic       [NSRC-1:0]      req,
    input  tsq_entry_t [NSRC-1:0]      req_ent,
    output logic                       out_valid,
    output tsq_entry_t                 out_ent,
    output logic                       collide
);
    logic       [NSRC-1:0] pend;
    tsq_entry_t [NSRC-1:0] slot;
    logic       [NSRC-1:0] gmask;

    // lowest index wins
    always_comb begin
        gmask   = '0;
        out_ent = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                gmask      = '0;
                gmask[i]   = 1'b1;
                out_ent    = slot[i];
            end
        end
    end

    assign out_valid = |pend;
    assign collide   = |(req & pend & ~gmask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            slot <= '0;
        end else begin
            for (int i = 0; i < NSRC; i++) begin
                if (req[i] && (!pend[i] || gmask[i])) begin
                    pend[i] <= 1'b1;
                    slot[i] <= req_ent[i];
                end else if (gmask[i]) begin
                    pend[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/tsq_fifo.sv
module tsq_fifo
    import tsq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_valid,
    input  tsq_entry_t                   wr_ent,
    input  logic                         rd_pop,
    output tsq_entry_t                   head,
    output logic                         not_empty,
    output logic                         full,
    output logic                         drop,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    tsq_entry_t        mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt, cnt_nxt;
    tsq_qstate_e       st, st_nxt;
    logic              do_wr, do_rd;

    assign do_wr   = wr_valid && (st != Q_FULL);
    assign do_rd   = rd_pop && (st != Q_EMPTY);
    assign cnt_nxt = cnt + CNT_W'(do_wr) - CNT_W'(do_rd);

    always_comb begin
        st_nxt = st;
        unique case (st)
            Q_EMPTY:   if (do_wr) st_nxt = (cnt_nxt == CNT_W'(DEPTH)) ? Q_FULL : Q_PARTIAL;
            Q_PARTIAL: begin
                if (cnt_nxt == '0)                 st_nxt = Q_EMPTY;
                else if (cnt_nxt == CNT_W'(DEPTH)) st_nxt = Q_FULL;
            end
            Q_FULL:    if (do_rd) st_nxt = (cnt_nxt == '0) ? Q_EMPTY : Q_PARTIAL;
            default:   st_nxt = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= Q_EMPTY;
            cnt    <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
            if (do_wr) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_ent;
    end

    always_comb begin
        not_empty = 1'b0;
        full      = 1'b0;
        unique case (st)
            Q_EMPTY:   ;
            Q_PARTIAL: not_empty = 1'b1;
            Q_FULL:    begin not_empty = 1'b1; full = 1'b1; end
            default:   ;
        endcase
    end

    assign head  = mem[rd_ptr];
    assign drop  = wr_valid && (st == Q_FULL);
    assign count = cnt;
endmodule

// File: rtl/tsq_event_queue.sv
module tsq_event_queue
    import tsq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int HW_CH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [63:0]         ts_now,
    input  logic [HW_CH-1:0]    hw_in,
    input  logic                pkt_valid,
    input  logic                pkt_is_tx,
    input  logic [15:0]         pkt_seq,
    input  logic [3:0]          pkt_mtype,
    input  logic [4:0]          pkt_port,
    input  logic [7:0]          pkt_domain,
    input  logic                cmp_hit,
    input  logic                reg_wr,
    input  logic [3:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                irq_o
);
    localparam int NSRC    = HW_CH + 3;
    localparam int PKT_IDX = HW_CH + 1;
    localparam int CMP_IDX = HW_CH + 2;
    localparam int CNT_W   = $clog2(DEPTH + 1);

    logic [HW_CH-1:0]      hw_en, hw_rise;
    logic                  irq_en, ovf;
    logic                  sw_push, pop_req, ovf_clr, ovf_set;
    logic [NSRC-1:0]       req;
    tsq_entry_t [NSRC-1:0] req_ent;
    logic                  arb_valid, collide;
    tsq_entry_t            arb_ent, head;
    logic                  not_empty, full, fifo_drop;
    logic [CNT_W-1:0]      fifo_cnt;
    logic [31:0]           ctrl_rd;
    logic                  unused_wdata;

    assign unused_wdata = ^reg_wdata;

    assign sw_push = reg_wr && (reg_addr == A_PUSH) && reg_wdata[0];
    assign pop_req = reg_wr && (reg_addr == A_POP)  && reg_wdata[0];
    assign ovf_clr = reg_wr && (reg_addr == A_RAW)  && reg_wdata[1];
    assign ovf_set = collide | fifo_drop;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_en  <= '0;
            irq_en <= 1'b0;
            ovf    <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_CTRL)  hw_en  <= reg_wdata[8 +: HW_CH];
            if (reg_wr && reg_addr == A_IRQEN) irq_en <= reg_wdata[0];
            if (ovf_set)      ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

    tsq_sync_edge #(.N(HW_CH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (hw_in),
        .en       (hw_en),
        .rise     (hw_rise)
    );

    always_comb begin
        req[0]     = sw_push;
        req_ent[0] = '{ts: ts_now, domain: 8'd0, port: 5'd0, etype: EV_PUSH,
                       mtype: 4'd0, seq: 16'd0};
        for (int i = 0; i < HW_CH; i++) begin
            req[1+i]     = hw_rise[i];
            req_ent[1+i] = '{ts: ts_now, domain: 8'd0, port: 5'(i + 1), etype: EV_HWIN,
                             mtype: 4'd0, seq: 16'd0};
        end
        req[PKT_IDX]     = pkt_valid;
        req_ent[PKT_IDX] = '{ts: ts_now, domain: pkt_domain, port: pkt_port,
                             etype: (pkt_is_tx ? EV_TX : EV_RX),
                             mtype: pkt_mtype, seq: pkt_seq};
        req[CMP_IDX]     = cmp_hit;
        req_ent[CMP_IDX] = '{ts: ts_now, domain: 8'd0, port: 5'd0, etype: EV_CMP,
                             mtype: 4'd0, seq: 16'd0};
    end

    tsq_arbiter #(.NSRC(NSRC)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_ent   (req_ent),
        .out_valid (arb_valid),
        .out_ent   (arb_ent),
        .collide   (collide)
    );

    tsq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (arb_valid),
        .wr_ent    (arb_ent),
        .rd_pop    (pop_req),
        .head      (head),
        .not_empty (not_empty),
        .full      (full),
        .drop      (fifo_drop),
        .count     (fifo_cnt)
    );

    always_comb begin
        ctrl_rd                = '0;
        ctrl_rd[8 +: HW_CH]    = hw_en;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:  reg_rdata = ctrl_rd;
            A_IRQEN: reg_rdata = {31'd0, irq_en};
            A_RAW:   reg_rdata = {30'd0, ovf, not_empty};
            A_MASK:  reg_rdata = {31'd0, not_empty & irq_en};
            A_TSLO:  if (not_empty) reg_rdata = head.ts[31:0];
            A_DESC:  if (not_empty) reg_rdata = {3'd0, head.port, head.etype, head.mtype, head.seq};
            A_DOM:   if (not_empty) reg_rdata = {24'd0, head.domain};
            A_TSHI:  if (not_empty) reg_rdata = head.ts[63:32];
            default: reg_rdata = '0;
        endcase
    end

    assign irq_o = not_empty & irq_en;
endmodule

// File: rtl/tsq_event_queue_chk.sv
module tsq_event_queue_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             pop_req,
    input logic             arb_valid,
    input logic             ovf,
    input logic             ovf_clr
);
    // R6: interrupt only with something queued
    p_irq_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (fifo_cnt != '0));

    // R9: occupancy bounded by depth
    p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));

    // R5: pop on empty leaves it empty
    p_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == '0 && pop_req && !arb_valid) |=> (fifo_cnt == '0));

    // R9: overflow flag is sticky
    p_sticky_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    // R9: write into a full queue is dropped and flagged
    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == CNT_W'(DEPTH) && arb_valid && !pop_req) |=> (fifo_cnt == CNT_W'(DEPTH) && ovf));

    // R8: at most one entry enters per cycle
    p_one_per_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt > $past(fifo_cnt)) |-> (fifo_cnt == $past(fifo_cnt) + 1'b1));
endmodule

bind tsq_event_queue tsq_event_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .fifo_cnt  (fifo_cnt),
    .pop_req   (pop_req),
    .arb_valid (arb_valid),
    .ovf       (ovf),
    .ovf_clr   (ovf_clr)
);

// File: tb/tsq_event_queue_bench.sv
module tsq_event_queue_bench;

    typedef struct packed {
        logic        tx;
        logic [15:0] seq;
        logic [3:0]  mt;
        logic [4:0]  port;
        logic [7:0]  dom;
    } pkt_vec_t;

    localparam int NVEC = 6;
    localparam pkt_vec_t VEC [NVEC] = '{
        '{1'b0, 16'h0001, 4'h0, 5'd1,  8'h00},
        '{1'b1, 16'hBEEF, 4'h3, 5'd2,  8'h7F},
        '{1'b0, 16'hFFFF, 4'hF, 5'd31, 8'hFF},
        '{1'b1, 16'h0000, 4'h8, 5'd0,  8'h01},
        '{1'b0, 16'h1234, 4'h9, 5'd16, 8'hA5},
        '{1'b1, 16'h8000, 4'hB, 5'd5,  8'h3C}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] ts_now = '0;
    logic [7:0]  hw_in = '0;
    logic        pkt_valid = 1'b0, pkt_is_tx = 1'b0;
    logic [15:0] pkt_seq = '0;
    logic [3:0]  pkt_mtype = '0;
    logic [4:0]  pkt_port = '0;
    logic [7:0]  pkt_domain = '0;
    logic        cmp_hit = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    tsq_event_queue u_tsq_event_queue (
        .clk(clk), .rst_n(rst_n), .ts_now(ts_now), .hw_in(hw_in),
        .pkt_valid(pkt_valid), .pkt_is_tx(pkt_is_tx), .pkt_seq(pkt_seq),
        .pkt_mtype(pkt_mtype), .pkt_port(pkt_port), .pkt_domain(pkt_domain),
        .cmp_hit(cmp_hit), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic logic [31:0] desc(input logic [4:0] port, input logic [3:0] et,
                                         input logic [3:0] mt, input logic [15:0] seq);
        return {3'd0, port, et, mt, seq};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_head(input string tag, input logic [63:0] ts, input logic [31:0] dsc,
                              input logic [7:0] dom);
        logic [31:0] lo, de, dm, hi;
        rd(4'd6, lo); rd(4'd7, de); rd(4'd8, dm); rd(4'd9, hi);
        chk({tag, " ts"}, {hi, lo}, ts);
        chk({tag, " desc"}, {32'd0, de}, {32'd0, dsc});
        chk({tag, " domain"}, {32'd0, dm}, {56'd0, dom});
    endtask

    task automatic pop();
        wr(4'd5, 32'd1);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd2, v); chk("R1 raw", v, 0);
        rd(4'd3, v); chk("R1 masked", v, 0);
        rd(4'd0, v); chk("R1 ctrl", v, 0);
        chk("R1 irq", irq_o, 0);

        // R2 R3 packet vectors through the table
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            ts_now = 64'h0123_4567_0000_0100 + 64'(i);
            pkt_valid = 1'b1; pkt_is_tx = VEC[i].tx; pkt_seq = VEC[i].seq;
            pkt_mtype = VEC[i].mt; pkt_port = VEC[i].port; pkt_domain = VEC[i].dom;
            @(negedge clk);
            pkt_valid = 1'b0;
            idle(2);
            rd(4'd2, v); chk("R6 raw pending", {63'd0, v[0]}, 1);
            check_head("R2 R3 pkt", 64'h0123_4567_0000_0100 + 64'(i),
                       desc(VEC[i].port, VEC[i].tx ? 4'd5 : 4'd4, VEC[i].mt, VEC[i].seq),
                       VEC[i].dom);
            pop(); idle(1);
            rd(4'd2, v); chk("R4 empty after pop", {63'd0, v[0]}, 0);
        end

        // R3 software push, R6 interrupt masking
        @(negedge clk); ts_now = 64'hAAAA_0000_5555_0001;
        wr(4'd4, 32'd1); idle(2);
        check_head("R3 push", 64'hAAAA_0000_5555_0001, desc(5'd0, 4'd0, 4'd0, 16'd0), 8'd0);
        rd(4'd3, v); chk("R6 masked off", v, 0);
        chk("R6 irq off", irq_o, 0);
        wr(4'd1, 32'd1);
        rd(4'd3, v); chk("R6 masked on", v, 1);
        chk("R6 irq on", irq_o, 1);
        pop(); idle(1);
        chk("R6 irq after drain", irq_o, 0);
        wr(4'd1, 32'd0);

        // R5 pop on empty is ignored
        pop(); pop(); idle(1);
        rd(4'd2, v); chk("R5 still empty", v, 0);
        @(negedge clk); ts_now = 64'd777;
        cmp_hit = 1'b1; @(negedge clk); cmp_hit = 1'b0; idle(2);
        rd(4'd2, v); chk("R5 one entry", {63'd0, v[0]}, 1);
        check_head("R5 R3 compare", 64'd777, desc(5'd0, 4'd6, 4'd0, 16'd0), 8'd0);
        pop(); idle(1);
        rd(4'd2, v); chk("R5 drained", v, 0);

        // R7 R10 hardware channel 3 only, held high; channel 5 disabled
        wr(4'd0, 32'h0000_0400);
        rd(4'd0, v); chk("R7 ctrl readback", v, 32'h0000_0400);
        @(negedge clk); ts_now = 64'd4242;
        hw_in = 8'b0001_0100;
        idle(20);
        hw_in = 8'd0;
        idle(6);
        check_head("R7 hw ch3", 64'd4242, desc(5'd3, 4'd3, 4'd0, 16'd0), 8'd0);
        pop(); idle(1);
        rd(4'd2, v); chk("R10 R7 single event", v, 0);

        // R8 simultaneous sources
        wr(4'd0, 32'h0000_FF00);
        @(negedge clk); ts_now = 64'd9000;
        hw_in = 8'b0100_0010;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd4; reg_wdata = 32'd1;
        pkt_valid = 1'b1; pkt_is_tx = 1'b0; pkt_seq = 16'h0042; pkt_mtype = 4'h1;
        pkt_port = 5'd9; pkt_domain = 8'h11;
        cmp_hit = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; pkt_valid = 1'b0; cmp_hit = 1'b0;
        idle(8);
        hw_in = 8'd0;
        check_head("R8 first push", 64'd9000, desc(5'd0, 4'd0, 4'd0, 16'd0), 8'd0);
        pop();
        check_head("R8 second hw2", 64'd9000, desc(5'd2, 4'd3, 4'd0, 16'd0), 8'd0);
        pop();
        check_head("R8 third hw7", 64'd9000, desc(5'd7, 4'd3, 4'd0, 16'd0), 8'd0);
        pop();
        check_head("R8 fourth pkt", 64'd9000, desc(5'd9, 4'd4, 4'h1, 16'h0042), 8'h11);
        pop();
        check_head("R8 fifth compare", 64'd9000, desc(5'd0, 4'd6, 4'd0, 16'd0), 8'd0);
        pop(); idle(4);
        rd(4'd2, v); chk("R8 drained", v, 0);
        wr(4'd0, 32'd0);

        // R9 fill to depth then overflow; R4 order
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); ts_now = 64'd1000 + 64'(i);
            wr(4'd4, 32'd1);
        end
        idle(2);
        rd(4'd2, v); chk("R9 full no ovf", v, 1);
        @(negedge clk); ts_now = 64'd5000;
        wr(4'd4, 32'd1); idle(2);
        rd(4'd2, v); chk("R9 ovf set", v, 3);
        for (int i = 0; i < 16; i++) begin
            logic [31:0] lo;
            rd(4'd6, lo);
            chk("R4 order", {32'd0, lo}, 64'd1000 + 64'(i));
            pop();
        end
        idle(1);
        rd(4'd2, v); chk("R9 sticky after drain", v, 2);
        wr(4'd2, 32'd2);
        rd(4'd2, v); chk("R9 ovf cleared", v, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule